// File: doc/BRIEF.md
# Phase-Shifted Chroma Carrier Generator

This block produces the square-wave colour subcarrier for a retro video chip whose pixel clock equals the colour carrier frequency, so every pixel spans exactly one carrier cycle. It runs from a fast clock at sixteen times the pixel rate. A free-running phase counter splits each pixel into sixteen steps, and the carrier edges are placed on those steps. The delay in steps is set by the hue nibble (upper four bits) of an 8-bit colour value. The block also gives a pixel-rate enable and a grey flag for downstream luma and mixing logic.

Two line standards are supported. In the 60 Hz mode the hue maps straight to a delay. In the 50 Hz mode a line-parity bit flips at every line-start strobe. On lines where it is set, the hue nibble is complemented before the delay is chosen. A small set of hue codes is forced to grey so that greyscale codes stay grey on both line polarities. A new colour is taken only at a pixel boundary, so a change in the middle of a pixel never cuts the carrier short.

Top module: `chroma_phase_gen`

## Requirements
- R1: Only bits [7:4] of `color_i` (the hue) affect `chroma_o` and `grey_o`. Bits [3:0] have no effect on either output.
- R2: Number the cycles of a pixel as steps 0 to 15, where step 0 is the cycle in which `pix_en_o` is high. For a non-grey effective hue h, `chroma_o` is high on steps s where ((s - 7 - h) mod 16) < 8, and low on all other steps.
- R3: A hue of 0 gives `grey_o` = 1 and `chroma_o` held low for the whole pixel, in both modes.
- R4: `pix_en_o` is high for exactly one fast-clock cycle in every 16. The first pulse comes 16 cycles after reset is released.
- R5: A line-parity bit toggles on every cycle in which `line_start_i` is high. In 50 Hz mode (`pal_mode_i` = 1), while the parity bit is 1, the effective hue is 15 - n for hue field n.
- R6: In 50 Hz mode, hue code 14 produces grey on both line polarities.
- R7: In 50 Hz mode, hue codes 1 and 13 produce grey on both line polarities.
- R8: `color_i` and `pal_mode_i` are sampled only at the clock edge that starts step 0. Changes at any other step do not alter the current pixel's carrier or `grey_o`.
- R9: Synchronous active-high reset clears the phase counter and the line-parity bit and drives `grey_o` = 1, `chroma_o` = 0 and `pix_en_o` = 0.
- R10: In 60 Hz mode (`pal_mode_i` = 0) the parity bit has no effect, and hue codes 1, 13 and 14 give normal carrier phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 16x the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| color_i | input | 8 | Colour value; hue in bits [7:4] |
| line_start_i | input | 1 | One-cycle strobe at each line start |
| pal_mode_i | input | 1 | 1 = 50 Hz line-alternating mode, 0 = 60 Hz mode |
| chroma_o | output | 1 | Phase-shifted square-wave carrier |
| grey_o | output | 1 | High when the current pixel carries no chroma |
| pix_en_o | output | 1 | One-cycle pulse at step 0 of each pixel |

## Verification
All three outputs are registered in the same cycle as the phase counter. For any pixel, the carrier value for step s appears s cycles after the `pix_en_o` cycle, and `grey_o` holds its value from that cycle onward. A colour driven before a `pix_en_o` pulse becomes visible in the cycle of that pulse. The bench drives inputs and samples outputs on falling edges. It changes the colour, waits for the next `pix_en_o`, and records the 16 following carrier samples as one pattern. A line-start strobe counts once it has been held for one rising edge, so the bench's parity model flips at that point, and the mid-pixel test changes the colour only after step 5 has been recorded.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic {
    VMODE_60HZ = 1'b0,
    VMODE_50HZ = 1'b1
  } vmode_e;

  typedef enum logic {
    LINE_PLAIN   = 1'b0,
    LINE_FLIPPED = 1'b1
  } line_pol_e;
endpackage

// File: rtl/cpg_phase_ctr.sv
module cpg_phase_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] phase_o,
  output logic         last_o,
  output logic         pix_en_o
);
  localparam logic [W-1:0] LAST_STEP = {W{1'b1}};

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      pix_en_o <= 1'b0;
    end else begin
      phase_q  <= phase_q + 1'b1;
      pix_en_o <= (phase_q == LAST_STEP);
    end
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == LAST_STEP);
endmodule

// File: rtl/cpg_line_parity.sv
module cpg_line_parity
  import cpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      line_start_i,
  output line_pol_e pol_o
);
  line_pol_e pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= LINE_PLAIN;
    end else if (line_start_i) begin
      pol_q <= (pol_q == LINE_PLAIN) ? LINE_FLIPPED : LINE_PLAIN;
    end
  end

  assign pol_o = pol_q;
endmodule

// File: rtl/cpg_hue_map.sv
module cpg_hue_map
  import cpg_pkg::*;
#(
  parameter int HUE_W = 4,
  parameter int SUP_A = 1,
  parameter int SUP_B = 13,
  parameter int SUP_C = 14
) (
  input  logic [HUE_W-1:0] hue_i,
  input  vmode_e           mode_i,
  input  line_pol_e        pol_i,
  output logic [HUE_W-1:0] hue_eff_o,
  output logic             grey_o
);
  localparam logic [HUE_W-1:0] CODE_A = HUE_W'(SUP_A);
  localparam logic [HUE_W-1:0] CODE_B = HUE_W'(SUP_B);
  localparam logic [HUE_W-1:0] CODE_C = HUE_W'(SUP_C);

  logic alt_mode;
  logic is_black;
  logic is_banned;

  always_comb begin
    alt_mode  = (mode_i == VMODE_50HZ);
    is_black  = (hue_i == '0);
    is_banned = (hue_i == CODE_A) || (hue_i == CODE_B) || (hue_i == CODE_C);
    grey_o    = is_black || (alt_mode && is_banned);
    if (alt_mode && (pol_i == LINE_FLIPPED)) begin
      hue_eff_o = ~hue_i;
    end else begin
      hue_eff_o = hue_i;
    end
  end
endmodule

// File: rtl/cpg_carrier_out.sv
module cpg_carrier_out #(
  parameter int W          = 4,
  parameter int BASE_DELAY = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] phase_i,
  input  logic         last_i,
  input  logic [W-1:0] hue_i,
  input  logic         grey_i,
  output logic         chroma_o,
  output logic         grey_o
);
  localparam logic [W-1:0] BASE = W'(BASE_DELAY);

  logic [W-1:0] held_hue_q;
  logic         held_grey_q;
  logic [W-1:0] hue_n;
  logic         grey_n;
  logic [W-1:0] phase_n;
  logic [W-1:0] offset_n;

  always_comb begin
    hue_n    = last_i ? hue_i  : held_hue_q;
    grey_n   = last_i ? grey_i : held_grey_q;
    phase_n  = phase_i + 1'b1;
    offset_n = phase_n - (BASE + hue_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_hue_q  <= '0;
      held_grey_q <= 1'b1;
      chroma_o    <= 1'b0;
      grey_o      <= 1'b1;
    end else begin
      held_hue_q  <= hue_n;
      held_grey_q <= grey_n;
      chroma_o    <= !grey_n && !offset_n[W-1];
      grey_o      <= grey_n;
    end
  end
endmodule

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen
  import cpg_pkg::*;
#(
  parameter int COLOR_W    = 8,
  parameter int PHASE_W    = 4,
  parameter int BASE_DELAY = 7,
  parameter int SUP_A      = 1,
  parameter int SUP_B      = 13,
  parameter int SUP_C      = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COLOR_W-1:0] color_i,
  input  logic               line_start_i,
  input  logic               pal_mode_i,
  output logic               chroma_o,
  output logic               grey_o,
  output logic               pix_en_o
);
  localparam int HUE_W = PHASE_W;
  localparam int LUM_W = COLOR_W - HUE_W;

  logic [PHASE_W-1:0] phase;
  logic               last_step;
  line_pol_e          pol;
  vmode_e             mode;
  logic [HUE_W-1:0]   hue_raw;
  logic [HUE_W-1:0]   hue_eff;
  logic               grey_sel;
  logic               unused_low_bits;

  assign hue_raw         = color_i[COLOR_W-1 -: HUE_W];
  assign unused_low_bits = ^color_i[LUM_W-1:0];
  assign mode            = pal_mode_i ? VMODE_50HZ : VMODE_60HZ;

  cpg_phase_ctr #(.W(PHASE_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .phase_o  (phase),
    .last_o   (last_step),
    .pix_en_o (pix_en_o)
  );

  cpg_line_parity u_par (
    .clk          (clk),
    .rst          (rst),
    .line_start_i (line_start_i),
    .pol_o        (pol)
  );

  cpg_hue_map #(
    .HUE_W (HUE_W),
    .SUP_A (SUP_A),
    .SUP_B (SUP_B),
    .SUP_C (SUP_C)
  ) u_map (
    .hue_i     (hue_raw),
    .mode_i    (mode),
    .pol_i     (pol),
    .hue_eff_o (hue_eff),
    .grey_o    (grey_sel)
  );

  cpg_carrier_out #(
    .W          (PHASE_W),
    .BASE_DELAY (BASE_DELAY)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .phase_i  (phase),
    .last_i   (last_step),
    .hue_i    (hue_eff),
    .grey_i   (grey_sel),
    .chroma_o (chroma_o),
    .grey_o   (grey_o)
  );
endmodule

// File: rtl/chroma_phase_gen_chk.sv
module chroma_phase_gen_chk #(
  parameter int PHASE_W = 4
) (
  input logic clk,
  input logic rst,
  input logic chroma_o,
  input logic grey_o,
  input logic pix_en_o
);
  logic [PHASE_W-1:0] step_q;
  logic               started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= '0;
      started_q <= 1'b0;
    end else begin
      step_q <= step_q + 1'b1;
      if (step_q == {PHASE_W{1'b1}}) started_q <= 1'b1;
    end
  end

  a_r4_en_on_step0: assert property (@(posedge clk) disable iff (rst)
    pix_en_o |-> (step_q == '0));

  a_r4_en_every_pixel: assert property (@(posedge clk) disable iff (rst)
    (started_q && step_q == '0) |-> pix_en_o);

  a_r4_en_single: assert property (@(posedge clk) disable iff (rst)
    pix_en_o |=> !pix_en_o);

  a_r3_grey_is_low: assert property (@(posedge clk) disable iff (rst)
    grey_o |-> !chroma_o);

  a_r8_grey_held: assert property (@(posedge clk) disable iff (rst)
    !pix_en_o |-> $stable(grey_o));

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (grey_o && !chroma_o && !pix_en_o));
endmodule

bind chroma_phase_gen chroma_phase_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .chroma_o (chroma_o),
  .grey_o   (grey_o),
  .pix_en_o (pix_en_o)
);

// File: tb/tb_chroma_phase_gen.sv
module tb_chroma_phase_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] color_i = 8'h00;
  logic       line_start_i = 1'b0;
  logic       pal_mode_i = 1'b0;
  logic       chroma_o, grey_o, pix_en_o;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic par = 1'b0;

  always #10 clk = ~clk;

  chroma_phase_gen dut (
    .clk(clk), .rst(rst), .color_i(color_i), .line_start_i(line_start_i),
    .pal_mode_i(pal_mode_i), .chroma_o(chroma_o), .grey_o(grey_o), .pix_en_o(pix_en_o)
  );

  typedef struct packed { logic pal; logic ls; logic [7:0] color; } vec_t;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h00},  // R3 grey in 60 Hz mode
    '{1'b0, 1'b0, 8'h10},  // R2 delay 8
    '{1'b0, 1'b0, 8'h9F},  // R2 delay wraps to 0
    '{1'b0, 1'b0, 8'h2A},  // R2 delay 9
    '{1'b0, 1'b0, 8'hE3},  // R10 code 14 not suppressed
    '{1'b0, 1'b0, 8'hD0},  // R10 code 13 not suppressed
    '{1'b0, 1'b1, 8'h50},  // R10 parity set, no flip
    '{1'b1, 1'b0, 8'h50},  // R5 flipped: 5 -> 10
    '{1'b1, 1'b1, 8'h50},  // R5 plain again
    '{1'b1, 1'b0, 8'hE0},  // R6 grey
    '{1'b1, 1'b0, 8'h1C},  // R7 grey
    '{1'b1, 1'b1, 8'hD4},  // R7 grey on flipped line
    '{1'b1, 1'b0, 8'h20},  // R5 2 -> 13, not suppressed
    '{1'b1, 1'b0, 8'hF0},  // R5 15 -> 0 gives chroma
    '{1'b1, 1'b1, 8'h00},  // R3 grey in 50 Hz mode
    '{1'b1, 1'b0, 8'hF0}   // R5 plain 15
  };

  function automatic logic [15:0] pat_for(input logic [3:0] d);
    logic [15:0] p;
    for (int k = 0; k < 16; k++) p[k] = (4'(k[3:0] - d) < 4'd8);
    return p;
  endfunction

  function automatic logic [16:0] model(input logic pal, input logic pr, input logic [7:0] c);
    logic [3:0] raw, eff;
    logic g;
    raw = c[7:4];
    g = (raw == 4'd0) || (pal && (raw == 4'd1 || raw == 4'd13 || raw == 4'd14));
    eff = (pal && pr) ? 4'(15 - raw) : raw;
    return {g, g ? 16'h0000 : pat_for(4'(4'd7 + eff))};
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual grey=%0b pat=%04h expected grey=%0b pat=%04h",
               tag, act[16], act[15:0], exp[16], exp[15:0]);
    end
  endtask

  task automatic pulse_line();
    line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    par = ~par;
  endtask

  // From a negedge, wait for the next step-0 cycle and record 16 steps.
  task automatic grab(output logic [16:0] r);
    @(negedge clk);
    while (!pix_en_o) @(negedge clk);
    r[16] = grey_o;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      r[k] = chroma_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [16:0] r;
    int gap;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset outputs", {grey_o, 13'd0, pix_en_o, 1'b0, chroma_o}, {1'b1, 16'h0000});
    rst = 1'b0;
    // R4: first pulse 16 cycles after release, then every 16, one cycle wide
    gap = 0;
    @(negedge clk);
    gap = 1;
    while (!pix_en_o) begin @(negedge clk); gap++; end
    check("R4 first pulse delay", 17'(gap), 17'd16);
    @(negedge clk);
    check("R4 pulse width", {16'd0, pix_en_o}, 17'd0);
    gap = 1;
    while (!pix_en_o) begin @(negedge clk); gap++; end
    check("R4 pulse period", 17'(gap), 17'd16);

    // Table walk: R2 R3 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].ls) pulse_line();
      pal_mode_i = VECS[i].pal;
      color_i = VECS[i].color;
      grab(r);
      check($sformatf("R2_R10 vector %0d", i), r, model(VECS[i].pal, par, VECS[i].color));
    end

    // R1: low nibble sweep has no effect
    pal_mode_i = 1'b0;
    for (int lo = 0; lo < 16; lo += 5) begin
      color_i = {4'd6, 4'(lo)};
      grab(r);
      check("R1 low nibble ignored", r, model(1'b0, par, 8'h60));
    end

    // R8: change colour in the middle of a pixel
    color_i = 8'h30;
    grab(r);
    @(negedge clk);
    while (!pix_en_o) @(negedge clk);
    r[16] = grey_o;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      r[k] = chroma_o;
      if (k == 5) color_i = 8'hB0;
    end
    check("R8 no mid-pixel change", r, model(1'b0, par, 8'h30));
    grab(r);
    check("R8 new colour next pixel", r, model(1'b0, par, 8'hB0));

    // R8: mode change mid-pixel does not alter grey
    color_i = 8'hE0;
    grab(r);
    @(negedge clk);
    pal_mode_i = 1'b1;
    @(negedge clk);
    check("R8 grey held mid-pixel", {grey_o, 16'h0}, {1'b0, 16'h0});

    // R9: reset clears line parity
    if (!par) pulse_line();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    par = 1'b0;
    pal_mode_i = 1'b1;
    color_i = 8'h20;
    grab(r);
    check("R9 parity cleared", r, model(1'b1, 1'b0, 8'h20));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule